// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands over a fixed number of clock cycles, one multiplier bit per cycle. It holds a single double-width accumulator. The lower half of that accumulator starts out holding the multiplier. Each cycle, bit 0 of the accumulator decides whether the multiplicand is added into the upper half. Then the whole accumulator moves one place to the right, so the multiplier bits are used up as the product grows in from the top. Because of this, the block needs only one single-width adder and no separate multiplier register.

A client raises `start` for one cycle with both operands present while the block is idle. It then waits for the one-cycle `done` pulse. At that point the high and low halves of the product appear on `hi` and `lo`. They stay there until the next multiply completes.

Top module: `shadd_mul_unit`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: When `start` is 1 and `busy` is 0 at a rising edge, `op_a` (the multiplicand) and `op_b` (the multiplier) are captured at that edge, and `busy` is 1 from that edge on.
- R3: If an operation is accepted at edge k, then `done` is 1 for exactly one cycle, after edge k+WIDTH. It is 0 after every edge between k and k+WIDTH. `busy` falls at edge k+WIDTH.
- R4: In the `done` cycle, `{hi, lo}` equals the full 2*WIDTH-bit unsigned product `op_a * op_b`. `hi` is the upper WIDTH bits and `lo` is the lower WIDTH bits.
- R5: The adder's carry-out becomes the top accumulator bit on the shift, so no product bit is lost. For example, all-ones times all-ones gives hi = all-ones minus 1 and lo = 1.
- R6: A `start`, or any operand change, while `busy` is 1 has no effect on the result or on the completion cycle of the operation in flight.
- R7: `hi` and `lo` change only at the edge that raises `done`. Between completions they hold their value, whatever `start` and the operands do.
- R8: A zero operand on either side gives a zero product. Small operands give the exact product, e.g. 2 × 3 = 6.
- R9: A `start` given in the same cycle as `done` is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply; honoured only while idle |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | WIDTH | Upper half of the last product |
| lo | output | WIDTH | Lower half of the last product |

## Verification
The assertions assume that `rst` is high from time zero until the first edges have passed. They also treat `start` while `busy` as a legal input that must be ignored, not as a protocol violation. They make no assumption about operand values. The stimulus changes inputs only on falling clock edges. It mixes random operands with all-ones, zero, single-bit and small cases. It deliberately raises `start` mid-operation with different operands, and it chains a new `start` into a `done` cycle.

// File: rtl/shadd_mul_pkg.sv
package shadd_mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_t;
endpackage

// File: rtl/shadd_mul_adder.sv
module shadd_mul_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] s,
  output logic             co
);
  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign s[i]       = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  assign co = carry[WIDTH];
endmodule

// File: rtl/shadd_mul_ctrl.sv
module shadd_mul_ctrl
  import shadd_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  mul_state_t      state;
  logic [CNT_W-1:0] iter;

  assign busy   = (state == ST_RUN);
  assign load   = (state == ST_IDLE) && start;
  assign step   = busy;
  assign finish = busy && (iter == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          iter <= '0;
          if (start) state <= ST_RUN;
        end
        ST_RUN: begin
          iter <= iter + 1'b1;
          if (iter == LAST) begin
            state <= ST_IDLE;
            iter  <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted start enters the run state with a fresh count
  p_enter_run_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && iter == '0));

  // R6: a run in progress advances regardless of start
  p_run_advances_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> (busy && iter == $past(iter) + 1'b1));

  // R3: the final iteration leaves the run state
  p_finish_exits_r3: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);
endmodule

// File: rtl/shadd_mul_dp.sv
module shadd_mul_dp #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   a_in,
  input  logic [WIDTH-1:0]   b_in,
  output logic [2*WIDTH-1:0] acc_next
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand;
  logic [PW-1:0]    acc;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             cout;

  assign addend = acc[0] ? mcand : '0;

  shadd_mul_adder #(.WIDTH(WIDTH)) adder_i (
    .x  (acc[PW-1:WIDTH]),
    .y  (addend),
    .s  (sum),
    .co (cout)
  );

  assign acc_next = {cout, sum, acc[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      mcand <= '0;
    end else if (load) begin
      mcand <= a_in;
      acc   <= {{WIDTH{1'b0}}, b_in};
    end else if (step) begin
      acc <= acc_next;
    end
  end

  // R2/R4: load clears the upper half and places the multiplier low
  p_load_init_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (acc[PW-1:WIDTH] == '0 && acc[WIDTH-1:0] == $past(b_in)));

  // R4: a zero bit 0 means a pure right shift with zero fill
  p_skip_add_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !acc[0]) |=> (acc[PW-1] == 1'b0 && acc[PW-2:WIDTH-1] == $past(acc[PW-1:WIDTH])));

  // R5: two set top bits in an add must carry into the top accumulator bit
  p_carry_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (step && acc[0] && acc[PW-1] && mcand[WIDTH-1]) |=> acc[PW-1]);
endmodule

// File: rtl/shadd_mul_unit.sv
module shadd_mul_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  localparam int PW = 2 * WIDTH;

  logic          load;
  logic          step;
  logic          finish;
  logic [PW-1:0] acc_next;

  shadd_mul_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy)
  );

  shadd_mul_dp #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .a_in     (op_a),
    .b_in     (op_b),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      hi   <= '0;
      lo   <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        hi <= acc_next[PW-1:WIDTH];
        lo <= acc_next[WIDTH-1:0];
      end
    end
  end

  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: completion coincides with idle
  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: results hold between completions
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !finish |=> ($stable(hi) && $stable(lo)));
endmodule

// File: tb/shadd_mul_unit_tb.sv
module shadd_mul_unit_tb_top;
  localparam int WIDTH = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [WIDTH-1:0] op_a = '0;
  logic [WIDTH-1:0] op_b = '0;
  logic             busy;
  logic             done;
  logic [WIDTH-1:0] hi;
  logic [WIDTH-1:0] lo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shadd_mul_unit #(.WIDTH(WIDTH)) dut_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op_a  (op_a),
    .op_b  (op_b),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo)
  );

  function automatic logic [2*WIDTH-1:0] expect_prod(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    logic [2*WIDTH-1:0] wa = {{WIDTH{1'b0}}, a};
    logic [2*WIDTH-1:0] wb = {{WIDTH{1'b0}}, b};
    return wa * wb;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [2*WIDTH-1:0] act, input logic [2*WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // call at a falling edge; raises start for one edge
  task automatic begin_op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", {63'b0, busy}, 64'd1);
  endtask

  // waits WIDTH edges after acceptance; inj>0 raises start with other operands mid-run
  task automatic finish_op(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                           input int inj, input string req);
    logic [2*WIDTH-1:0] exp = expect_prod(a, b);
    int early = 0;
    for (int c = 1; c <= WIDTH; c++) begin
      @(negedge clk);
      if (c == inj) begin
        start = 1'b1;
        op_a  = ~a;
        op_b  = b ^ 32'h5A5A_0F0F;
      end else begin
        start = 1'b0;
        op_a  = a + 32'(c);
      end
      if (c < WIDTH && done !== 1'b0) early++;
    end
    chk(early == 0, "R3", "done before completion", 64'(early), 64'd0);
    chk(done === 1'b1 && busy === 1'b0, "R3", "done/busy at completion",
        {62'b0, done, busy}, 64'd2);
    chk({hi, lo} === exp, req, "product", {hi, lo}, exp);
  endtask

  task automatic run_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b, input string req);
    @(negedge clk);
    begin_op(a, b);
    finish_op(a, b, 0, req);
  endtask

  initial begin
    logic [2*WIDTH-1:0] held;
    logic [WIDTH-1:0]   ra;
    logic [WIDTH-1:0]   rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && {hi, lo} === '0, "R1", "state in reset",
        {hi, lo}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && {hi, lo} === '0, "R1", "state after reset",
        {hi, lo}, 64'd0);

    run_mul(32'd2, 32'd3, "R8");
    run_mul(32'd0, 32'hDEAD_BEEF, "R8");
    run_mul(32'hCAFE_F00D, 32'd0, "R8");
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    run_mul(32'h8000_0000, 32'h8000_0000, "R5");
    run_mul(32'hFFFF_FFFF, 32'd1, "R4");
    run_mul(32'd1, 32'h8000_0001, "R4");

    // R7: hold after done, even with changed operands and no start
    held = {hi, lo};
    op_a = 32'h1234_5678;
    op_b = 32'h9ABC_DEF0;
    repeat (5) @(negedge clk);
    chk({hi, lo} === held && done === 1'b0 && busy === 1'b0, "R7", "result held when idle",
        {hi, lo}, held);

    // R6: start mid-run with different operands is ignored
    @(negedge clk);
    begin_op(32'h0001_2345, 32'h0ABC_0001);
    finish_op(32'h0001_2345, 32'h0ABC_0001, 7, "R6");
    @(negedge clk);
    begin_op(32'hF0F0_F0F0, 32'h0F0F_0F0F);
    finish_op(32'hF0F0_F0F0, 32'h0F0F_0F0F, WIDTH - 1, "R6");

    // R9: chain a start into the done cycle
    begin_op(32'd7, 32'd9);
    finish_op(32'd7, 32'd9, 0, "R9");
    begin_op(32'hFFFF_0000, 32'h0000_FFFF);
    finish_op(32'hFFFF_0000, 32'h0000_FFFF, 0, "R9");
    @(negedge clk);
    chk(done === 1'b0, "R3", "done lasts one cycle", {63'b0, done}, 64'd0);

    for (int n = 0; n < 40; n++) begin
      ra = $urandom();
      rb = $urandom();
      if (n % 8 == 3) ra = 32'h1 << (n % WIDTH);
      if (n % 8 == 5) rb = ~(32'h1 << (n % WIDTH));
      run_mul(ra, rb, "R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule